// File: doc/BRIEF.md
# Region Write-Lock Array

This block keeps a write-lock flag for every protected region of a flash array and answers, for any address, whether a program or erase there may proceed. The array is split into 64KB blocks. The lowest and the highest block are divided further into 4KB sectors, and each of those sectors has its own flag. Every block in between is covered by a single flag. All flags come up locked, so nothing in the array can be written until it is released one region at a time.

Commands arrive as a single-cycle strobe with an opcode and an address. The lock and release opcodes change the flag for the region that holds the address, but only while the write-enable input is high. The query opcode returns that flag one cycle later. A scheme-select input chooses which protection governs the permit outputs. When it is low, the result of an external range-protect decoder is passed through. When it is high, the lock flags are used. A separate chip-wide permit tells an erase-everything operation whether it may run.

Top module: `region_lock_array`

## Requirements
- R1: The lowest block (address bits [24:16] all 0) and the highest block (address bits [24:16] all 1) each hold 16 independent flags, one per 4KB sector, selected by address bits [15:12]. Changing one sector's flag leaves its neighbouring sectors unchanged.
- R2: Every other 64KB block has one flag. Any address inside the block selects that flag, and the flags of neighbouring blocks are unaffected.
- R3: After reset every flag reads 1 (locked).
- R4: A command with opcode 8'h39 while wr_en is 1 clears the flag of the addressed region. The new value takes effect from the next clock edge.
- R5: A command with opcode 8'h36 while wr_en is 1 sets the flag of the addressed region.
- R6: Opcodes 8'h36 and 8'h39 issued while wr_en is 0 leave every flag unchanged.
- R7: A command with opcode 8'h3D raises rd_valid for exactly one cycle, one clock after the command, and rd_bit then carries the flag of the addressed region. Any opcode other than 8'h36, 8'h39 and 8'h3D changes no flag and raises no rd_valid.
- R8: With scheme_sel at 1, permit is the inverse of the flag covering chk_addr. This is combinational from chk_addr and the stored flags.
- R9: With scheme_sel at 0, permit equals the inverse of range_prot, regardless of the flags.
- R10: With scheme_sel at 1, chip_erase_ok is 1 only when no flag in the whole array is set. With scheme_sel at 0, it is the inverse of range_prot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; sets every flag |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 8 | Command opcode (36h lock, 39h release, 3Dh query) |
| cmd_addr | input | ADDR_W | Byte address selecting the region for the command |
| wr_en | input | 1 | Write enable; qualifies lock and release commands |
| scheme_sel | input | 1 | 0: range protect governs, 1: lock flags govern |
| range_prot | input | 1 | Result from the external range-protect decoder (1 = protected) |
| chk_addr | input | ADDR_W | Address whose write permission is being asked |
| permit | output | 1 | Program or erase at chk_addr is allowed |
| chip_erase_ok | output | 1 | An erase of the whole array is allowed |
| rd_valid | output | 1 | Query response strobe |
| rd_bit | output | 1 | Flag value returned by a query |

## Verification
On every cycle, the assertions check how the flags evolve after commands: release clears the addressed flag, lock sets it, nothing changes without a qualified write, and a query answers in exactly one cycle. They also check that the permit outputs agree with each other under each scheme. Only the bench's scenarios can show that the address decoding reaches the right region, meaning the sector boundaries in the two end blocks and the block boundaries elsewhere. The bench also shows that every flag is locked after reset and that the chip-wide permit opens only after all 542 regions have been released.

// File: rtl/region_lock_pkg.sv
package region_lock_pkg;

   typedef enum logic [7:0] {
      OP_LOCK    = 8'h36,
      OP_RELEASE = 8'h39,
      OP_QUERY   = 8'h3D
   } lock_op_e;

   // number of flags for a given geometry: end blocks split, middle blocks whole
   function automatic int flag_count(input int blk_bits, input int sec_bits);
      return (1 << blk_bits) - 2 + 2 * (1 << sec_bits);
   endfunction

endpackage

// File: rtl/lock_addr_decode.sv
module lock_addr_decode #(
   parameter int ADDR_W    = 25,
   parameter int BLK_SHIFT = 16,
   parameter int SEC_SHIFT = 12,
   parameter int IDX_W     = 10
) (
   input  logic [ADDR_W-1:SEC_SHIFT] addr_hi,
   output logic [IDX_W-1:0]          idx
);
   localparam int BLK_W   = ADDR_W - BLK_SHIFT;
   localparam int SEC_W   = BLK_SHIFT - SEC_SHIFT;
   localparam int NUM_BLK = 1 << BLK_W;
   localparam int SEC_PER = 1 << SEC_W;
   localparam int NBITS   = region_lock_pkg::flag_count(BLK_W, SEC_W);
   localparam int TOP_BASE = SEC_PER + NUM_BLK - 2;

   logic [BLK_W-1:0] blk;
   logic [SEC_W-1:0] sec;

   assign blk = addr_hi[ADDR_W-1:BLK_SHIFT];
   assign sec = addr_hi[BLK_SHIFT-1:SEC_SHIFT];

   // layout: bottom sectors, then middle blocks, then top sectors
   always_comb begin
      if (blk == '0)
         idx = IDX_W'(sec);
      else if (blk == '1)
         idx = IDX_W'(TOP_BASE) + IDX_W'(sec);
      else
         idx = IDX_W'(SEC_PER - 1) + IDX_W'(blk);
   end

   // R1 / R2: every address lands inside the flag array
   always_comb begin
      a_r1_index_in_range: assert (int'(idx) < NBITS);
   end

endmodule

// File: rtl/lock_flag_store.sv
module lock_flag_store #(
   parameter int NBITS = 542,
   parameter int IDX_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  logic             wr_val,
   input  logic [IDX_W-1:0] wr_idx,
   output logic [NBITS-1:0] flags_q,
   output logic             any_set
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '1;
      end else if (wr_stb) begin
         for (int i = 0; i < NBITS; i++) begin
            if (wr_idx == IDX_W'(i)) flags_q[i] <= wr_val;
         end
      end
   end

   assign any_set = |flags_q;

   // R6: flags only move on a write strobe
   a_r6_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(flags_q));

   // at most one flag changes per write
   a_r6_single_flag_change: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> ($countones(flags_q ^ $past(flags_q)) <= 1));

endmodule

// File: rtl/region_lock_array.sv
module region_lock_array #(
   parameter int ADDR_W    = 25,
   parameter int BLK_SHIFT = 16,
   parameter int SEC_SHIFT = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              wr_en,
   input  logic              scheme_sel,
   input  logic              range_prot,
   input  logic [ADDR_W-1:0] chk_addr,
   output logic              permit,
   output logic              chip_erase_ok,
   output logic              rd_valid,
   output logic              rd_bit
);
   import region_lock_pkg::*;

   localparam int BLK_W = ADDR_W - BLK_SHIFT;
   localparam int SEC_W = BLK_SHIFT - SEC_SHIFT;
   localparam int NBITS = flag_count(BLK_W, SEC_W);
   localparam int IDX_W = $clog2(NBITS);

   generate
      if (SEC_SHIFT >= BLK_SHIFT) begin : g_bad_sec
         $error("sector shift must be below block shift");
      end
      if (BLK_W < 2) begin : g_bad_blk
         $error("need at least four blocks");
      end
      if (BLK_SHIFT >= ADDR_W) begin : g_bad_addr
         $error("address too narrow for block size");
      end
   endgenerate

   logic [IDX_W-1:0] cmd_idx, chk_idx;
   logic [NBITS-1:0] flags_q;
   logic             any_set;
   logic             is_lock, is_release, is_query, wr_stb;
   logic             unused_low;

   assign unused_low = ^{cmd_addr[SEC_SHIFT-1:0], chk_addr[SEC_SHIFT-1:0]};

   lock_addr_decode #(
      .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .SEC_SHIFT(SEC_SHIFT), .IDX_W(IDX_W)
   ) u_cmd_dec (
      .addr_hi(cmd_addr[ADDR_W-1:SEC_SHIFT]),
      .idx    (cmd_idx)
   );

   lock_addr_decode #(
      .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .SEC_SHIFT(SEC_SHIFT), .IDX_W(IDX_W)
   ) u_chk_dec (
      .addr_hi(chk_addr[ADDR_W-1:SEC_SHIFT]),
      .idx    (chk_idx)
   );

   assign is_lock    = cmd_valid && (cmd_op == OP_LOCK);
   assign is_release = cmd_valid && (cmd_op == OP_RELEASE);
   assign is_query   = cmd_valid && (cmd_op == OP_QUERY);
   assign wr_stb     = wr_en && (is_lock || is_release);

   lock_flag_store #(.NBITS(NBITS), .IDX_W(IDX_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (wr_stb),
      .wr_val (is_lock),
      .wr_idx (cmd_idx),
      .flags_q(flags_q),
      .any_set(any_set)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_bit   <= 1'b0;
      end else begin
         rd_valid <= is_query;
         rd_bit   <= is_query ? flags_q[cmd_idx] : 1'b0;
      end
   end

   assign permit        = scheme_sel ? !flags_q[chk_idx] : !range_prot;
   assign chip_erase_ok = scheme_sel ? !any_set          : !range_prot;

   a_r4_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (is_release && wr_en) |=> !flags_q[$past(cmd_idx)]);

   a_r5_lock_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (is_lock && wr_en) |=> flags_q[$past(cmd_idx)]);

   a_r6_no_write_unqualified: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && wr_en) |=> $stable(flags_q));

   a_r7_query_answers: assert property (@(posedge clk) disable iff (!rst_n)
      is_query |=> rd_valid);

   a_r7_no_spurious_answer: assert property (@(posedge clk) disable iff (!rst_n)
      !is_query |=> !rd_valid);

   a_r9_schemes_agree: assert property (@(posedge clk) disable iff (!rst_n)
      !scheme_sel |-> (permit == chip_erase_ok));

   a_r10_chip_implies_region: assert property (@(posedge clk) disable iff (!rst_n)
      (scheme_sel && chip_erase_ok) |-> permit);

endmodule

// File: tb/region_lock_array_tb.sv
module region_lock_array_tb;
   localparam int AW = 25;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [7:0] cmd_op = 8'h00;
   logic [AW-1:0] cmd_addr = '0;
   logic wr_en = 1'b0;
   logic scheme_sel = 1'b1;
   logic range_prot = 1'b0;
   logic [AW-1:0] chk_addr = '0;
   logic permit, chip_erase_ok, rd_valid, rd_bit;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   bit    exp_q[$];
   string tag_q[$];
   bit    model[int];

   always #4 clk = ~clk;

   region_lock_array u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .wr_en(wr_en), .scheme_sel(scheme_sel),
      .range_prot(range_prot), .chk_addr(chk_addr), .permit(permit),
      .chip_erase_ok(chip_erase_ok), .rd_valid(rd_valid), .rd_bit(rd_bit)
   );

   function automatic int region_key(input logic [AW-1:0] a);
      int blk = int'(a >> 16);
      int sec = int'((a >> 12) & 25'hF);
      if (blk == 0 || blk == 511) return blk * 16 + sec;
      return blk * 16;
   endfunction

   function automatic bit m_locked(input logic [AW-1:0] a);
      int k = region_key(a);
      if (model.exists(k)) return model[k];
      return 1'b1;
   endfunction

   function automatic bit m_any_locked();
      for (int b = 0; b < 512; b++) begin
         if (b == 0 || b == 511) begin
            for (int s = 0; s < 16; s++)
               if (m_locked(AW'(b * 65536 + s * 4096))) return 1'b1;
         end else if (m_locked(AW'(b * 65536))) return 1'b1;
      end
      return 1'b0;
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic finish_up();
      if (exp_q.size() != 0) begin
         total++; bad++;
         $display("FAIL R7: actual=%0d pending answers expected=0", exp_q.size());
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   task automatic send(input logic [7:0] op, input logic [AW-1:0] a, input logic we);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; wr_en = we;
      if (we && op == 8'h36) model[region_key(a)] = 1'b1;
      if (we && op == 8'h39) model[region_key(a)] = 1'b0;
      @(negedge clk);
      cmd_valid = 1'b0; wr_en = 1'b0;
   endtask

   task automatic query(input string req, input logic [AW-1:0] a);
      exp_q.push_back(m_locked(a));
      tag_q.push_back(req);
      send(8'h3D, a, 1'b0);
   endtask

   task automatic probe(input string req, input logic [AW-1:0] a, input logic sch, input logic rp);
      @(negedge clk);
      chk_addr = a; scheme_sel = sch; range_prot = rp;
      #1;
      check(req, permit, sch ? !m_locked(a) : !rp);
   endtask

   // monitor: pops expected answers as the design produces them
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL R7: actual=unexpected answer expected=none");
         end else begin
            automatic bit e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(t, rd_bit, e);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R3: everything locked after reset
      query("R3", 25'h0000000);
      query("R3", 25'h0123456);
      query("R3", 25'h1FFFFFF);
      probe("R3", 25'h0A00000, 1'b1, 1'b0);
      #1 check("R3", chip_erase_ok, 1'b0);

      // R9: range protect governs under scheme 0
      probe("R9", 25'h0A00000, 1'b0, 1'b0);
      probe("R9", 25'h0A00000, 1'b0, 1'b1);
      #1 check("R10", chip_erase_ok, 1'b0);
      scheme_sel = 1'b0; range_prot = 1'b0;
      #1 check("R10", chip_erase_ok, 1'b1);

      // R6: release without write enable is ignored
      send(8'h39, 25'h0050000, 1'b0);
      probe("R6", 25'h0050000, 1'b1, 1'b0);
      query("R6", 25'h0050000);

      // R4 / R2: release middle block 5, block granularity
      send(8'h39, 25'h0050000, 1'b1);
      probe("R4", 25'h0050000, 1'b1, 1'b0);
      probe("R2", 25'h005FFFF, 1'b1, 1'b0);
      probe("R2", 25'h0060000, 1'b1, 1'b0);
      probe("R2", 25'h004FFFF, 1'b1, 1'b0);
      query("R2", 25'h0058000);
      probe("R9", 25'h0050000, 1'b0, 1'b1);

      // R1: sector granularity at both ends
      send(8'h39, 25'h0003000, 1'b1);
      probe("R1", 25'h0003ABC, 1'b1, 1'b0);
      probe("R1", 25'h0004000, 1'b1, 1'b0);
      probe("R1", 25'h0002FFF, 1'b1, 1'b0);
      send(8'h39, 25'h1FFF000, 1'b1);
      probe("R1", 25'h1FFF800, 1'b1, 1'b0);
      probe("R1", 25'h1FFE000, 1'b1, 1'b0);
      query("R1", 25'h1FFE123);
      query("R1", 25'h1FFF123);

      // R7: unknown opcode gives no answer and changes nothing
      send(8'h20, 25'h0060000, 1'b1);
      check("R7", rd_valid, 1'b0);
      probe("R7", 25'h0060000, 1'b1, 1'b0);
      probe("R7", 25'h0050000, 1'b1, 1'b0);

      // R6: lock without write enable ignored; R5: lock with it
      send(8'h36, 25'h0050000, 1'b0);
      probe("R6", 25'h0050000, 1'b1, 1'b0);
      send(8'h36, 25'h0050000, 1'b1);
      probe("R5", 25'h0050000, 1'b1, 1'b0);
      query("R5", 25'h0050000);

      // R10: release all regions, chip erase opens
      for (int b = 0; b < 512; b++) begin
         if (b == 0 || b == 511) begin
            for (int s = 0; s < 16; s++) send(8'h39, AW'(b * 65536 + s * 4096), 1'b1);
         end else send(8'h39, AW'(b * 65536), 1'b1);
      end
      @(negedge clk);
      scheme_sel = 1'b1;
      #1 check("R10", chip_erase_ok, !m_any_locked());
      probe("R8", 25'h1234567, 1'b1, 1'b1);
      send(8'h36, 25'h1FF7000, 1'b1);
      #1 check("R10", chip_erase_ok, !m_any_locked());
      probe("R8", 25'h1FF7000, 1'b1, 1'b0);
      probe("R1", 25'h1FF6000, 1'b1, 1'b0);
      range_prot = 1'b0; scheme_sel = 1'b0;
      #1 check("R10", chip_erase_ok, 1'b1);

      repeat (3) @(negedge clk);
      done = 1'b1;
      finish_up();
   end

endmodule